// File: doc/BRIEF.md
# SPI Master with Bit-Granular Bursts

This block is an SPI master whose transfer length is set in bits rather than in words. Software programs one length field holding the bit count minus one, with a range of 1 to 4096 bits, and a half-period divider. It pushes 32-bit words into a 64-entry transmit queue and starts the burst. The block then lowers the chip select, clocks out exactly the programmed number of bits most significant bit first in SPI mode 0, and raises the chip select once after the last bit.

A burst shorter than a word takes only the low bits of its word. A burst longer than a word chains words under one chip-select frame. When the length is not a multiple of 32, the first word supplies the odd remainder and every later word supplies all 32 bits. Received bits are packed in the same way and are pushed right-aligned into a 64-entry receive queue.

If the transmit queue runs dry partway through a burst, the clock pauses low while the frame stays open, and the burst resumes when software pushes the next word. All control goes through a small register port: configuration, start, transmit push, receive pop, and status with a sticky overflow flag.

Top module: `spi_burst_master`

## Requirements
- R1: One burst produces exactly LEN+1 rising SCK edges, where LEN is bits 11:0 of the configuration register (address 0), so the burst covers 1 to 4096 bits.
- R2: MOSI carries the burst MSB first. The first word contributes only its low ((LEN mod 32)+1) bits, and every later word contributes bits 31 down to 0.
- R3: SS_N is driven low exactly once per burst and stays low across all word boundaries until the final bit has completed.
- R4: With the transmit queue supplied, consecutive rising SCK edges in a burst are exactly 2*H system clocks apart. H is the divider in bits 23:16 of the configuration register, and a value of 0 acts as 1.
- R5: Mode 0 is used. SCK is low whenever SS_N is high, MOSI never changes on the clock where SCK rises, and MISO is sampled when SCK rises.
- R6: Received bits are assembled MSB first into words that mirror the transmit split. Each word, and the partial first word, is pushed right-aligned (zero-filled above) into the receive queue, which is read by popping at address 3.
- R7: If the transmit queue is empty at a word boundary inside a burst, SCK holds low and SS_N stays low until a word is pushed at address 2. The burst then continues without losing bits.
- R8: Writing 1 to bit 0 of address 1 starts a burst only when the block is idle and the transmit queue is not empty. Otherwise the write has no effect.
- R9: The busy flag (status bit 0) is set from the chip-select fall until the chip-select rise after the last bit.
- R10: Status at address 4 reads busy at bit 0, transmit empty at bit 1, transmit full at bit 2, receive empty at bit 3, receive full at bit 4 and overflow at bit 5. After reset it reads 0x0A.
- R11: A received word that completes while the receive queue is full is dropped and sets the sticky overflow flag. The flag stays set until a write to address 4 with bit 5 high.
- R12: Writes to the configuration register while busy are ignored.
- R13: Each queue holds 64 words. A push into a full transmit queue is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at address 3) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low chip select |

## Verification
A register write takes effect on the clock edge inside the write cycle, so status bits reflect it from the next read. The first SCK rise follows the chip-select fall by H clocks, and later rises follow at 2*H intervals. The bench therefore measures pin behaviour from timestamps of SCK and SS_N edges and does not count cycles from the start write. Burst completion is detected by polling the busy bit, and the bench compares the captured MOSI stream, the rise spacing, the chip-select count and the popped receive words only after busy clears. For the underrun case, it waits well past one word time before it samples the pins and the status.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] A_GO   = 3'd1;
  localparam logic [ADDR_W-1:0] A_TXD  = 3'd2;
  localparam logic [ADDR_W-1:0] A_RXD  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd4;

  localparam int DIV_LSB = 16;
  localparam int OVF_BIT = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_HIGH, ST_LOW, ST_WAIT, ST_TAIL
  } eng_state_t;

  // bits taken from the first word of a burst whose length register holds len_m1
  function automatic int unsigned head_bits(input int unsigned len_m1,
                                            input int unsigned word_w);
    return (len_m1 % word_w) + 1;
  endfunction

  // effective half period in system clocks
  function automatic int unsigned half_period(input int unsigned div);
    return (div == 0) ? 1 : div;
  endfunction

endpackage

// File: rtl/sbm_fifo.sv
module sbm_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sbm_tick.sv
module sbm_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim  = DIV_W'(sbm_pkg::half_period(32'(div)));
  assign tick = en && (cnt == lim - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sbm_engine.sv
module sbm_engine
  import sbm_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic              tick,
  input  logic              tx_empty,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              miso,
  output logic              tick_en,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [WORD_W-1:0] rx_data,
  output logic              sck,
  output logic              mosi,
  output logic              ss_n,
  output logic              busy
);
  localparam int LOG_W = $clog2(WORD_W);

  eng_state_t        state;
  logic [WORD_W-1:0] shreg, rxsh;
  logic [LEN_W:0]    bits_left;
  logic [LOG_W:0]    wbits;
  logic [LOG_W:0]    head;
  logic              last_bit, end_burst, launch, reload_now;

  assign head      = (LOG_W+1)'(head_bits(32'(len_m1), WORD_W));
  assign last_bit  = (wbits == (LOG_W+1)'(1));
  assign end_burst = (bits_left == (LEN_W+1)'(1));
  assign launch    = (state == ST_IDLE) && start && !tx_empty;
  assign reload_now = ((state == ST_HIGH) && tick && last_bit && !end_burst && !tx_empty)
                   || ((state == ST_WAIT) && !tx_empty);

  always_comb begin
    tick_en = (state == ST_LEAD) || (state == ST_HIGH) ||
              (state == ST_LOW)  || (state == ST_TAIL);
    rx_push = (state == ST_HIGH) && tick && last_bit;
    tx_pop  = launch || reload_now;
    rx_data = rxsh;
    busy    = (state != ST_IDLE);
    mosi    = ss_n ? 1'b0 : shreg[WORD_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      sck       <= 1'b0;
      ss_n      <= 1'b1;
      shreg     <= '0;
      rxsh      <= '0;
      bits_left <= '0;
      wbits     <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (launch) begin
            shreg     <= tx_data << (WORD_W - int'(head));
            wbits     <= head;
            bits_left <= {1'b0, len_m1} + 1'b1;
            rxsh      <= '0;
            ss_n      <= 1'b0;
            state     <= ST_LEAD;
          end
        end
        ST_LEAD, ST_LOW: begin
          if (tick) begin
            sck   <= 1'b1;
            rxsh  <= {rxsh[WORD_W-2:0], miso};
            state <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (tick) begin
            sck       <= 1'b0;
            bits_left <= bits_left - 1'b1;
            if (last_bit) begin
              rxsh <= '0;
              if (end_burst) begin
                state <= ST_TAIL;
              end else if (!tx_empty) begin
                shreg <= tx_data;
                wbits <= (LOG_W+1)'(WORD_W);
                state <= ST_LOW;
              end else begin
                state <= ST_WAIT;
              end
            end else begin
              shreg <= shreg << 1;
              wbits <= wbits - 1'b1;
              state <= ST_LOW;
            end
          end
        end
        ST_WAIT: begin
          if (!tx_empty) begin
            shreg <= tx_data;
            wbits <= (LOG_W+1)'(WORD_W);
            state <= ST_LOW;
          end
        end
        ST_TAIL: begin
          if (tick) begin
            ss_n  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import sbm_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 64,
  parameter int LEN_W  = 12,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              ss_n
);
  logic [LEN_W-1:0]  cfg_len;
  logic [DIV_W-1:0]  cfg_div;
  logic              go_req, tx_push, rx_pop, ovf_clr;
  logic              tx_empty, tx_full, rx_empty, rx_full;
  logic              tx_pop, rx_push, tick, tick_en, busy, rx_ovf;
  logic [WORD_W-1:0] tx_head, rx_head, rx_word;

  assign go_req  = reg_wr && (reg_addr == A_GO) && reg_wdata[0];
  assign tx_push = reg_wr && (reg_addr == A_TXD);
  assign rx_pop  = reg_rd && (reg_addr == A_RXD);
  assign ovf_clr = reg_wr && (reg_addr == A_STAT) && reg_wdata[OVF_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_len <= LEN_W'(WORD_W - 1);
      cfg_div <= DIV_W'(1);
    end else if (reg_wr && (reg_addr == A_CFG) && !busy) begin
      cfg_len <= reg_wdata[LEN_W-1:0];
      cfg_div <= reg_wdata[DIV_LSB +: DIV_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rx_ovf <= 1'b0;
    else if (rx_push && rx_full) rx_ovf <= 1'b1;
    else if (ovf_clr)            rx_ovf <= 1'b0;
  end

  sbm_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(reg_wdata),
    .pop(tx_pop), .rdata(tx_head), .empty(tx_empty), .full(tx_full));

  sbm_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_word),
    .pop(rx_pop), .rdata(rx_head), .empty(rx_empty), .full(rx_full));

  sbm_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(tick_en), .div(cfg_div), .tick(tick));

  sbm_engine #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(go_req), .len_m1(cfg_len), .tick(tick),
    .tx_empty(tx_empty), .tx_data(tx_head), .miso(miso), .tick_en(tick_en),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_word), .sck(sck),
    .mosi(mosi), .ss_n(ss_n), .busy(busy));

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CFG: begin
        reg_rdata[LEN_W-1:0]         = cfg_len;
        reg_rdata[DIV_LSB +: DIV_W]  = cfg_div;
      end
      A_RXD:  reg_rdata = rx_head;
      A_STAT: reg_rdata[OVF_BIT:0] = {rx_ovf, rx_full, rx_empty, tx_full, tx_empty, busy};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sbm_checker.sv
module sbm_checker (
  input logic clk,
  input logic rst_n,
  input logic sck,
  input logic ss_n,
  input logic mosi,
  input logic busy,
  input logic go_req,
  input logic tx_empty,
  input logic rx_push,
  input logic rx_full,
  input logic rx_ovf,
  input logic ovf_clr
);
  // R5
  idle_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n |-> !sck);

  // R5
  mosi_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $stable(mosi));

  // R9
  busy_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !ss_n);

  // R8
  empty_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_req && tx_empty && !busy) |=> !busy);

  // R11
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full) |=> rx_ovf);

  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovf && !ovf_clr) |=> rx_ovf);
endmodule

bind spi_burst_master sbm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .ss_n(ss_n), .mosi(mosi),
  .busy(busy), .go_req(go_req), .tx_empty(tx_empty), .rx_push(rx_push),
  .rx_full(rx_full), .rx_ovf(rx_ovf), .ovf_clr(ovf_clr));

// File: tb/spi_burst_master_tb.sv
`timescale 1ns/1ps
module spi_burst_master_tb;
  localparam int CLK_P = 10;
  localparam logic [2:0] A_CFG = 0, A_GO = 1, A_TXD = 2, A_RXD = 3, A_STAT = 4;

  logic clk = 0, rst_n = 0, reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic sck, mosi, miso, ss_n;

  int checks = 0, fails = 0;
  logic [31:0] txw [0:159];
  logic cap [0:4095];
  int cap_n = 0, sidx = 0, ss_rises = 0, gap_min = 0, gap_max = 0;
  bit rise_seen = 0;
  time last_t = 0;

  always #(CLK_P/2) clk = ~clk;

  spi_burst_master u_dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n));

  function automatic logic slv_bit(input int i);
    logic [31:0] x;
    x = 32'(i) * 32'h9E3779B1;
    return x[13] ^ x[27];
  endfunction

  assign miso = slv_bit(sidx);

  always @(negedge ss_n) begin
    sidx = 0; cap_n = 0; rise_seen = 0; gap_min = 1 << 20; gap_max = 0;
  end
  always @(negedge sck) if (!ss_n) sidx++;
  always @(posedge ss_n) ss_rises++;
  always @(posedge sck) begin
    if (cap_n < 4096) cap[cap_n] = mosi;
    cap_n++;
    if (rise_seen) begin
      int g;
      g = int'(($time - last_t) / CLK_P);
      if (g < gap_min) gap_min = g;
      if (g > gap_max) gap_max = g;
    end
    rise_seen = 1;
    last_t = $time;
  end

  function automatic int head_of(input int len);
    return ((len - 1) % 32) + 1;
  endfunction

  function automatic logic exp_tx_bit(input int len, input int k);
    int h, j;
    h = head_of(len);
    if (k < h) return txw[0][h-1-k];
    j = k - h;
    return txw[1 + j/32][31 - (j % 32)];
  endfunction

  function automatic logic [31:0] exp_rx_word(input int len, input int w);
    int h, first, n;
    logic [31:0] v;
    h = head_of(len);
    v = '0;
    if (w == 0) begin first = 0; n = h; end
    else begin first = h + (w-1)*32; n = 32; end
    for (int k = 0; k < n; k++) v = {v[30:0], slv_bit(first + k)};
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = (a == A_RXD); reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic run_burst(input int len, input int div, input bit stall,
                           input bit pop_rx, input bit pre);
    int nw, pushed, got, bad, exp_got, guard, first_push;
    logic [31:0] st, d, cfg_exp;
    nw = (len + 31) / 32;
    pushed = pre ? 64 : 0; got = 0; bad = 0;
    cfg_exp = (32'(div) << 16) | 32'(len - 1);
    wr(A_CFG, cfg_exp);
    first_push = stall ? 1 : ((nw < 64) ? nw : 64);
    if (!pre) for (int k = 0; k < first_push; k++) begin wr(A_TXD, txw[k]); pushed++; end
    ss_rises = 0;
    wr(A_GO, 32'h1);
    if (stall) begin
      repeat (100 + 80*div) @(negedge clk);
      rd(A_STAT, st);
      // R9 busy set while frame open
      chk(st[0] == 1, "R9 busy during stall", st[0], 1);
      // R7 clock parked low with frame open after first word
      chk(sck == 0 && ss_n == 0 && cap_n == 32, "R7 underrun hold",
          {sck, ss_n, 30'(cap_n)}, 32);
      // R12 config write while busy must not land
      wr(A_CFG, 32'h0002_0005);
    end
    guard = 0;
    while (guard < 30000) begin
      guard++;
      rd(A_STAT, st);
      if (pushed < nw && !st[2]) begin wr(A_TXD, txw[pushed]); pushed++; end
      else if (pop_rx && !st[3]) begin
        rd(A_RXD, d);
        if (d !== exp_rx_word(len, got)) bad++;
        got++;
      end else if (!st[0] && pushed == nw) break;
    end
    chk(guard < 30000, "R1 burst completion", guard, 0);
    if (!pop_rx && nw > 64) begin
      rd(A_STAT, st);
      // R11 overflow raised with receive queue full
      chk(st[4] && st[5], "R11 overflow flag", st, 32'h30);
    end
    while (1) begin
      rd(A_STAT, st);
      if (st[3]) break;
      rd(A_RXD, d);
      if (d !== exp_rx_word(len, got)) bad++;
      got++;
    end
    exp_got = pop_rx ? nw : ((nw > 64) ? 64 : nw);
    // R1 exact bit count
    chk(cap_n == len, "R1 sck rise count", cap_n, len);
    // R3 single chip-select frame
    chk(ss_rises == 1 && ss_n == 1, "R3 one frame", ss_rises, 1);
    for (int k = 0; k < len; k++) if (cap[k] !== exp_tx_bit(len, k)) bad += 1000;
    // R2 and R6 data on both lines
    chk(bad == 0 && got == exp_got, "R2/R6 data", {bad, got}, exp_got);
    if (!stall && len > 1) begin
      int hp;
      hp = (div == 0) ? 1 : div;
      // R4 uniform clock
      chk(gap_min == 2*hp && gap_max == 2*hp, "R4 sck spacing", {gap_min, gap_max}, 2*hp);
    end
    if (stall) begin
      rd(A_CFG, d);
      chk(d == cfg_exp, "R12 config frozen while busy", d, cfg_exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 190000);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] st;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(A_STAT, st);
    // R10 reset status
    chk(st == 32'h0A, "R10 reset status", st, 32'h0A);
    // R5 idle pins
    chk(sck == 0 && ss_n == 1, "R5 idle pins", {sck, ss_n}, 1);

    // R8 start with empty queue ignored
    wr(A_GO, 32'h1);
    repeat (5) @(negedge clk);
    rd(A_STAT, st);
    chk(st == 32'h0A && ss_n == 1, "R8 empty start", st, 32'h0A);

    txw[0] = 32'd1023; run_burst(8, 1, 0, 1, 0);   // R2 low byte only
    txw[0] = 32'hFFFF_FFFE; run_burst(1, 2, 0, 1, 0);
    txw[0] = 32'hA5C3_0F96; run_burst(32, 0, 0, 1, 0); // R4 divider 0 acts as 1
    txw[0] = 32'h1234_5678; txw[1] = 32'h9ABC_DEF0; run_burst(40, 3, 0, 1, 0);
    txw[0] = 32'hDEAD_BEEF; txw[1] = 32'h0BAD_F00D; run_burst(64, 1, 1, 1, 0); // R7

    for (int k = 0; k < 128; k++) txw[k] = $urandom;
    run_burst(4096, 1, 0, 1, 0);                   // R1 longest burst

    // R13 transmit queue depth
    for (int k = 0; k < 65; k++) begin txw[k] = $urandom; wr(A_TXD, txw[k]); end
    rd(A_STAT, st);
    chk(st[2] == 1, "R13 tx full after 64", st, 32'h4);
    run_burst(2048, 1, 0, 1, 1);
    rd(A_STAT, st);
    chk(st[1] == 1, "R13 extra push dropped", st, 32'h2);

    // R11 overflow: 65 words received without popping
    for (int k = 0; k < 65; k++) txw[k] = $urandom;
    run_burst(2080, 1, 0, 0, 0);
    rd(A_STAT, st);
    chk(st[3] && st[5], "R11 sticky after drain", st, 32'h28);
    wr(A_STAT, 32'h20);
    rd(A_STAT, st);
    chk(st[5] == 0, "R11 clear", st[5], 0);

    for (int r = 0; r < 8; r++) begin
      int len, div;
      len = 1 + int'($urandom % 300);
      div = int'($urandom % 4);
      for (int k = 0; k < 10; k++) txw[k] = $urandom;
      run_burst(len, div, 0, 1, 0);
    end
    finish_run();
  end
endmodule